// File: doc/BRIEF.md
# Selectable CAN Time-Quantum Enable Generator

This block produces the reference timing for a CAN protocol core. The core runs from a single fast system clock that stands for the 240 MHz source. The block does not create a derived clock. It emits a clock-enable pulse, one system cycle wide, at the rate picked through a 4-bit select register. The top select bit chooses between the slow source (80 MHz, which gives one pulse every 3 system cycles) and the fast source. When the fast source is chosen, a 3-bit code divides it by 4, 6, 8, 10 or 12.

Software writes the select value through a plain write strobe and reads it back on a separate bus. A select value that is not one of the six legal settings is stored as the slow-source setting, and the read-back shows the value after this correction. A status output gives the resulting rate in MHz. A hold input keeps the divide logic in reset while it is asserted. Every write also restarts the divide counter, so the first pulse after a write always comes one full new period later.

This is a control block and has no data stream: every pin is a plain level or strobe, with no back-pressure.

Top module: `can_tick_gen`

## Requirements
- R1: While rst_n is low, sel_rdata reads 0, rate_mhz reads 80 and tick_en stays low.
- R2: A stored select value of 0 (bit 3 clear) gives rate_mhz = 80, and tick_en pulses once every 3 clock cycles.
- R3: A stored select value with bit 3 set and bits 2:0 equal to code c (0 to 4) gives a tick period of 4 + 2*c cycles, so 0x8..0xC give periods 4, 6, 8, 10, 12 and rate_mhz 60, 40, 30, 24, 20.
- R4: A written value outside {0x0, 0x8, 0x9, 0xA, 0xB, 0xC} (0x1..0x7 and 0xD..0xF) is stored as 0x0 and behaves as in R2.
- R5: sel_rdata returns the stored value after correction, and rate_mhz returns the rate of that value in binary MHz. Both change only on the clock edge that samples sel_wr high.
- R6: While hold_rst is sampled high, tick_en stays low. After the last edge that samples it high, the first pulse comes in the cycle after the (N-1)-th following edge, where N is the current period.
- R7: An edge that samples sel_wr high restarts the count with the new period N. The first pulse comes in the cycle after the (N-1)-th following edge, whatever phase the old period was in.
- R8: Away from restarts, tick_en is high for exactly one cycle, and consecutive pulses are exactly N cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, standing for the fast 240 MHz source |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_rst | input | 1 | Holds the divide counter in reset while high |
| sel_wr | input | 1 | Write strobe for the select register |
| sel_wdata | input | 4 | Select value to write: bit 3 is the source, bits 2:0 the divider code |
| sel_rdata | output | 4 | Stored select value after correction |
| tick_en | output | 1 | One-cycle enable pulse at the selected rate |
| rate_mhz | output | 7 | Selected rate in MHz, binary |

## Verification
The hardest case to reach from the ports is a restart that lands in the middle of a period, or on the very cycle a pulse is high. In that case a counter that does not restart correctly would produce a short or stretched first interval.

The stimulus places writes a few cycles into a long period and issues writes back to back. It also holds reset for several cycles in the middle of a running period. The scoreboard tracks the expected phase from each restart, so every first interval and every later spacing is compared cycle by cycle. Illegal codes are interleaved with legal ones, so the stored correction shows on both the read-back and the pulse spacing.

// File: rtl/can_tick_pkg.sv
package can_tick_pkg;
  localparam int SEL_W      = 4;
  localparam int SRC_BIT    = 3;
  localparam int DIV_W      = 3;
  localparam int FAST_CODES = 5;
  localparam int FAST_BASE  = 4;
  localparam int FAST_STEP  = 2;
  localparam int SLOW_DIV   = 3;
  localparam int FAST_MHZ   = 240;
  localparam int SLOW_MHZ   = FAST_MHZ / SLOW_DIV;
  localparam int MAX_DIV    = FAST_BASE + FAST_STEP * (FAST_CODES - 1);
  localparam int CNT_W      = $clog2(MAX_DIV);
  localparam int RATE_W     = $clog2(FAST_MHZ / FAST_BASE + 1) + 1;
  localparam logic [SEL_W-1:0] SEL_SLOW = '0;

  // keep a fast-source value whose code is in range; map every other value to the slow setting
  function automatic logic [SEL_W-1:0] legalize(input logic [SEL_W-1:0] v);
    if (v[SRC_BIT] && (v[DIV_W-1:0] < DIV_W'(FAST_CODES)))
      return v;
    return SEL_SLOW;
  endfunction

  function automatic logic is_legal(input logic [SEL_W-1:0] v);
    return (v == SEL_SLOW) || (v[SRC_BIT] && (v[DIV_W-1:0] < DIV_W'(FAST_CODES)));
  endfunction
endpackage

// File: rtl/can_tick_selreg.sv
module can_tick_selreg
  import can_tick_pkg::*;
#(
  parameter int W = SEL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= SEL_SLOW;
    else if (wr) q_r <= legalize(wdata);
  end

  assign q = q_r;

  assert_store_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> is_legal(q));
  assert_keep_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/can_tick_decode.sv
module can_tick_decode
  import can_tick_pkg::*;
#(
  parameter int SW     = SEL_W,
  parameter int CW     = CNT_W,
  parameter int RW     = RATE_W,
  parameter int DW     = DIV_W,
  parameter int NCODES = FAST_CODES,
  parameter int BASE   = FAST_BASE,
  parameter int STEP   = FAST_STEP,
  parameter int SDIV   = SLOW_DIV,
  parameter int FMHZ   = FAST_MHZ
) (
  input  logic [SW-1:0] sel,
  output logic [CW-1:0] last,
  output logic [RW-1:0] mhz
);
  localparam int SMHZ = FMHZ / SDIV;

  logic [RW-1:0] rate_tab [NCODES];

  for (genvar i = 0; i < NCODES; i++) begin : g_rate
    assign rate_tab[i] = RW'(FMHZ / (BASE + STEP * i));
  end

  logic          fast;
  logic [DW-1:0] code;

  assign fast = sel[SW-1];
  assign code = sel[DW-1:0];

  always_comb begin
    if (fast) last = CW'(BASE - 1) + CW'(STEP) * CW'(code);
    else      last = CW'(SDIV - 1);
    mhz = RW'(SMHZ);
    for (int i = 0; i < NCODES; i++) begin
      if (fast && (code == DW'(i))) mhz = rate_tab[i];
    end
  end
endmodule

// File: rtl/can_tick_divider.sv
module can_tick_divider
  import can_tick_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] last,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (restart || cnt >= last) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == last);

  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
  assert_single_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  assert_min_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ##1 !tick ##1 !tick);
endmodule

// File: rtl/can_tick_gen.sv
module can_tick_gen
  import can_tick_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int CW = CNT_W,
  parameter int RW = RATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_rst,
  input  logic          sel_wr,
  input  logic [SW-1:0] sel_wdata,
  output logic [SW-1:0] sel_rdata,
  output logic          tick_en,
  output logic [RW-1:0] rate_mhz
);
  logic [SW-1:0] sel_q;
  logic [CW-1:0] last;
  logic          restart;

  assign restart = hold_rst | sel_wr;

  can_tick_selreg #(.W(SW)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_wdata), .q(sel_q)
  );

  can_tick_decode #(.SW(SW), .CW(CW), .RW(RW)) u_dec (
    .sel(sel_q), .last(last), .mhz(rate_mhz)
  );

  can_tick_divider #(.CW(CW)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .last(last), .tick(tick_en)
  );

  assign sel_rdata = sel_q;

  assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |=> !tick_en);
  assert_slow_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rdata == SEL_SLOW) |-> (rate_mhz == RW'(SLOW_MHZ)));
  assert_fast_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rdata == SW'(8)) |-> (rate_mhz == RW'(60)));
endmodule

// File: tb/can_tick_gen_bench.sv
`timescale 1ns/1ps
module can_tick_gen_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       hold_rst = 0;
  logic       sel_wr = 0;
  logic [3:0] sel_wdata = 0;
  logic [3:0] sel_rdata;
  logic       tick_en;
  logic [6:0] rate_mhz;

  can_tick_gen u_can_tick_gen (
    .clk(clk), .rst_n(rst_n), .hold_rst(hold_rst), .sel_wr(sel_wr),
    .sel_wdata(sel_wdata), .sel_rdata(sel_rdata), .tick_en(tick_en), .rate_mhz(rate_mhz)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [3:0] rb;
    int         per;
    int         mhz;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected behaviour of a written value, from R2, R3, R4
  function automatic exp_t expect_of(input logic [3:0] v);
    exp_t e;
    case (v)
      4'h0:    e = '{4'h0, 3, 80, "R2"};
      4'h8:    e = '{4'h8, 4, 60, "R3"};
      4'h9:    e = '{4'h9, 6, 40, "R3"};
      4'hA:    e = '{4'hA, 8, 30, "R3"};
      4'hB:    e = '{4'hB, 10, 24, "R3"};
      4'hC:    e = '{4'hC, 12, 20, "R3"};
      default: e = '{4'h0, 3, 80, "R4"};
    endcase
    return e;
  endfunction

  // scoreboard model state
  int         m_per = 3, m_cnt = 0, m_mhz = 80, since = 0, gap = 0;
  bit         gap_ok = 0;
  logic [3:0] m_rb = 0;
  string      m_tag = "R2", m_rtag = "R1";

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(tick_en == 1'b0, "R1", "tick_en in reset", tick_en, 0);
      chk(sel_rdata == 4'h0, "R1", "sel_rdata in reset", sel_rdata, 0);
      chk(rate_mhz == 7'd80, "R1", "rate_mhz in reset", rate_mhz, 80);
      m_per = 3; m_cnt = 0; m_mhz = 80; m_rb = 0; since = 0; gap_ok = 0;
      m_tag = "R2"; m_rtag = "R1";
    end else begin
      bit exp_tick;
      exp_tick = (m_cnt == m_per - 1);
      chk(tick_en == exp_tick, (since < m_per) ? m_rtag : m_tag, "tick_en", tick_en, exp_tick);
      chk(sel_rdata == m_rb, (m_tag == "R4") ? "R4" : "R5", "sel_rdata", sel_rdata, m_rb);
      chk(rate_mhz == 7'(m_mhz), "R5", "rate_mhz", rate_mhz, m_mhz);
      if (tick_en) begin
        if (gap_ok) chk(gap == m_per, "R8", "tick spacing", gap, m_per);
        gap = 1; gap_ok = 1;
      end else gap++;
      if (hold_rst || sel_wr) begin
        m_cnt = 0; since = 0; gap_ok = 0;
        if (sel_wr) begin
          m_rtag = "R7";
          if (q.size() == 0) chk(0, "R5", "scoreboard empty on write", 0, 1);
          else begin
            exp_t e;
            e = q.pop_front();
            m_rb = e.rb; m_per = e.per; m_mhz = e.mhz; m_tag = e.tag;
          end
        end
        if (hold_rst) m_rtag = "R6";
      end else begin
        m_cnt = (m_cnt == m_per - 1) ? 0 : m_cnt + 1;
        since++;
      end
    end
  end

  task automatic wr(input logic [3:0] v);
    @(posedge clk); #1;
    sel_wr = 1; sel_wdata = v;
    q.push_back(expect_of(v));
    @(posedge clk); #1;
    sel_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic hold(input int n);
    @(posedge clk); #1; hold_rst = 1;
    repeat (n) @(posedge clk);
    #1; hold_rst = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(20);                       // R2 default slow rate
    wr(4'h8); idle(25);             // R3 divide by 4
    wr(4'h9); idle(30);
    wr(4'hA); idle(40);
    wr(4'hB); idle(45);
    wr(4'hC); idle(50);
    wr(4'h5); idle(15);             // R4 illegal, slow side
    wr(4'h8);
    wr(4'hF); idle(12);             // R4 illegal, fast side
    wr(4'hD); idle(7);
    wr(4'h7); idle(9);
    wr(4'hC); idle(5);
    hold(7); idle(30);              // R6 hold mid-period
    wr(4'hA); idle(3);              // R7 restart mid-period
    wr(4'hB); idle(30);
    wr(4'h9); idle(5);              // R7 restart near a tick
    hold(1); idle(20);
    wr(4'h0); idle(12);
    wr(4'h0); idle(10);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule